// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block runs once after reset. It acts as a two-wire bus controller and copies its own configuration record from a shared serial EEPROM into a local register file. The bus is modelled one level above the wires. The block places a request holding the EEPROM device address byte and an 8-bit word address. A responder returns one data byte with an acknowledge pulse, or returns a negative acknowledge.

Several loaders can share one EEPROM. Each loader waits until its active-low chain enable input is low. When it finishes, it raises its done output, which drives the enable input of the next loader. Every loader first reads a 3-byte header. Header byte 0 holds three flags:
- a check-code enable,
- an address-map flag,
- a large-memory flag.

From these flags and its 4-bit strap value, the loader finds where its 37-byte record starts. It reads the record and then one check byte. It copies the record into its register file only when the check byte matches. Whether the check passes or fails, it always raises done.

Top module: `eeld_autoload`

## Requirements
- R1: `ownAddr` equals 0xB0 plus twice `strap`, giving 0xB0, 0xB2, 0xB4 and 0xB6 for straps 0 to 3.
- R2: After reset, no bus request is made while `chainEnN` is high. Loading begins once `chainEnN` is sampled low.
- R3: The first three transactions read word addresses 0, 1 and 2, in that order. In header byte 0, bit 0 enables the check code, bit 1 selects the address map, and bit 2 marks an EEPROM larger than 256 bytes.
- R4: With the map bit clear, the record starts at 3 + strap×37. With it set, one byte is first read at address 3 + strap, and that byte's value is the start address.
- R5: With the large bit set, the device byte is 0xA0 with address bits 9:8 placed in its bits 2:1, and the word address is address bits 7:0. With the large bit clear, the device byte is always 0xA0.
- R6: The 37 record bytes are read at start..start+36, followed by the check byte at start+37. On a pass, record byte k appears in `cfgFlat[8k+7:8k]`.
- R7: With checking enabled, the check byte must equal a CRC-8 of the record bytes (polynomial 0x07, initial value 0, most significant bit first). With checking disabled, the check byte must equal 0xA5.
- R8: On a check mismatch, `loadErr` rises, `cfgFlat` keeps its previous contents, and `allDone` still rises.
- R9: A negative acknowledge repeats the same transaction at the same address. After the fourth consecutive one (three retries), `loadErr` and `allDone` rise and no further requests are made.
- R10: `allDone` stays high once set, and `busReq` stays low from then on, whatever `chainEnN` does.
- R11: In reset, `busReq`, `allDone` and `loadErr` are low and `cfgFlat` is zero. A request holds its addresses stable until a response arrives and drops on the cycle after that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strap | input | 4 | Strap index of this loader |
| chainEnN | input | 1 | Active-low chain enable from the previous loader |
| busReq | output | 1 | Single-byte read transaction request |
| busDevAddr | output | 8 | EEPROM device address byte for the request |
| busWordAddr | output | 8 | Word address for the request |
| busAck | input | 1 | One-cycle pulse: the byte was read and `busData` is valid |
| busNack | input | 1 | One-cycle pulse: the transaction was not acknowledged |
| busData | input | 8 | Returned data byte |
| ownAddr | output | 8 | This loader's own bus address byte |
| cfgFlat | output | 296 | Register file, record byte k at bits 8k+7:8k |
| allDone | output | 1 | Load finished; drives the next loader's chain enable |
| loadErr | output | 1 | Check mismatch or retries exhausted |

## Verification
A corrupted start address, index or flag does not stay hidden. It shows at the request ports on the very next transaction, as a wrong device or word address in the request sequence that the bench compares entry by entry against the expected list. A bad check-code state or a faulty shadow copy appears only at the end, in `loadErr` and `cfgFlat`, one cycle after the check byte's acknowledge. For that reason, every scenario checks both the trace and the final register file. A retry counter that is off by one changes how many identical requests are issued for the first record byte. The scenario with exactly three refusals exposes it, as does the scenario with four.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

  // Load phase of the sequencer
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_MAP,
    PH_REC,
    PH_FIN
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic capFlags;
    logic capMap;
    logic capRec;
    logic commit;
    logic setErr;
    logic setDone;
  } ldStrb_t;

  // Flag positions inside header byte 0
  localparam int FLG_CRC = 0;
  localparam int FLG_MAP = 1;
  localparam int FLG_BIG = 2;

  // One byte of CRC-8, polynomial 0x07, MSB first
  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] d);
    logic [7:0] c;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/eeld_ctrl.sv
module eeld_ctrl
  import eeld_pkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    chainEnN,
  input  logic    busAck,
  input  logic    busNack,
  input  logic    hdrLast,
  input  logic    chkPos,
  input  logic    mapOn,
  input  logic    chkOk,
  output phase_t  phase,
  output logic    reqOn,
  output ldStrb_t strb
);

  localparam int RW = $clog2(MAX_RETRY + 1);

  phase_t        phaseNxt;
  logic          reqNxt;
  logic [RW-1:0] retry;
  logic [RW-1:0] retryNxt;

  always_comb begin
    strb     = '0;
    phaseNxt = phase;
    reqNxt   = reqOn;
    retryNxt = retry;
    case (phase)
      PH_IDLE: begin
        if (!chainEnN) begin
          phaseNxt    = PH_HDR;
          reqNxt      = 1'b1;
          strb.clrIdx = 1'b1;
        end
      end
      PH_FIN: reqNxt = 1'b0;
      default: begin
        if (!reqOn) begin
          reqNxt = 1'b1;
        end else if (busAck) begin
          reqNxt   = 1'b0;
          retryNxt = '0;
          case (phase)
            PH_HDR: begin
              strb.capFlags = 1'b1;
              if (hdrLast) begin
                strb.clrIdx = 1'b1;
                phaseNxt    = mapOn ? PH_MAP : PH_REC;
              end else begin
                strb.incIdx = 1'b1;
              end
            end
            PH_MAP: begin
              strb.capMap = 1'b1;
              strb.clrIdx = 1'b1;
              phaseNxt    = PH_REC;
            end
            PH_REC: begin
              if (chkPos) begin
                phaseNxt     = PH_FIN;
                strb.setDone = 1'b1;
                if (chkOk) strb.commit = 1'b1;
                else       strb.setErr = 1'b1;
              end else begin
                strb.capRec = 1'b1;
                strb.incIdx = 1'b1;
              end
            end
            default: ;
          endcase
        end else if (busNack) begin
          reqNxt = 1'b0;
          if (retry == RW'(MAX_RETRY)) begin
            phaseNxt     = PH_FIN;
            strb.setErr  = 1'b1;
            strb.setDone = 1'b1;
          end else begin
            retryNxt = retry + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      reqOn <= 1'b0;
      retry <= '0;
    end else begin
      phase <= phaseNxt;
      reqOn <= reqNxt;
      retry <= retryNxt;
    end
  end

endmodule

// File: rtl/eeld_dpath.sv
module eeld_dpath
  import eeld_pkg::*;
#(
  parameter int         REC_LEN   = 37,
  parameter int         HDR_LEN   = 3,
  parameter int         STRAP_W   = 4,
  parameter int         EE_AW     = 10,
  parameter logic [7:0] EE_DEV    = 8'hA0,
  parameter logic [7:0] OWN_BASE  = 8'hB0,
  parameter logic [7:0] FIXED_PAT = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STRAP_W-1:0]   strap,
  input  logic [7:0]           busData,
  input  phase_t               phase,
  input  ldStrb_t              strb,
  output logic [7:0]           devAddr,
  output logic [7:0]           wordAddr,
  output logic [7:0]           ownAddr,
  output logic                 hdrLast,
  output logic                 chkPos,
  output logic                 mapOn,
  output logic                 chkOk,
  output logic                 errQ,
  output logic                 doneQ,
  output logic [REC_LEN*8-1:0] cfgFlat
);

  localparam int IW   = $clog2(REC_LEN + 1);
  localparam int HI_W = EE_AW - 8;

  logic [IW-1:0]    idx;
  logic [2:0]       flags;
  logic [7:0]       mapStart;
  logic [7:0]       crc;
  logic [EE_AW-1:0] baseAddr;
  logic [EE_AW-1:0] curAddr;
  logic             crcEn;
  logic             bigEn;
  logic [7:0]       shadow [REC_LEN];
  logic [7:0]       cfg    [REC_LEN];

  assign crcEn   = flags[FLG_CRC];
  assign mapOn   = flags[FLG_MAP];
  assign bigEn   = flags[FLG_BIG];
  assign hdrLast = (idx == IW'(HDR_LEN - 1));
  assign chkPos  = (idx == IW'(REC_LEN));
  assign ownAddr = OWN_BASE + 8'({strap, 1'b0});
  assign chkOk   = (busData == (crcEn ? crc : FIXED_PAT));

  // Record start: map entry or strap-derived slot
  always_comb begin
    if (mapOn) baseAddr = EE_AW'(mapStart);
    else       baseAddr = EE_AW'(HDR_LEN) + EE_AW'(strap) * EE_AW'(REC_LEN);
  end

  always_comb begin
    case (phase)
      PH_HDR:  curAddr = EE_AW'(idx);
      PH_MAP:  curAddr = EE_AW'(HDR_LEN) + EE_AW'(strap);
      default: curAddr = baseAddr + EE_AW'(idx);
    endcase
  end

  // Upper address bits ride in the device byte for large memories
  always_comb begin
    devAddr  = EE_DEV;
    if (bigEn) devAddr = EE_DEV | 8'({curAddr[EE_AW-1:8], 1'b0});
    wordAddr = curAddr[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      flags    <= '0;
      mapStart <= '0;
      crc      <= '0;
      errQ     <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      if (strb.clrIdx) begin
        idx <= '0;
        crc <= '0;
      end else if (strb.incIdx) begin
        idx <= idx + 1'b1;
      end
      if (strb.capFlags && idx == '0) flags <= busData[2:0];
      if (strb.capMap) mapStart <= busData;
      if (strb.capRec) crc <= crc8Step(crc, busData);
      if (strb.setErr) errQ <= 1'b1;
      if (strb.setDone) doneQ <= 1'b1;
    end
  end

  // Shadow bytes take the record; the register file copies only on a pass
  for (genvar g = 0; g < REC_LEN; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (strb.capRec && idx == IW'(g)) shadow[g] <= busData;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cfg[g] <= '0;
      else if (strb.commit) cfg[g] <= shadow[g];
    end
    assign cfgFlat[g*8 +: 8] = cfg[g];
  end

endmodule

// File: rtl/eeld_autoload.sv
module eeld_autoload
  import eeld_pkg::*;
#(
  parameter int         REC_LEN   = 37,
  parameter int         HDR_LEN   = 3,
  parameter int         STRAP_W   = 4,
  parameter int         EE_AW     = 10,
  parameter int         MAX_RETRY = 3,
  parameter logic [7:0] EE_DEV    = 8'hA0,
  parameter logic [7:0] OWN_BASE  = 8'hB0,
  parameter logic [7:0] FIXED_PAT = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STRAP_W-1:0]   strap,
  input  logic                 chainEnN,
  output logic                 busReq,
  output logic [7:0]           busDevAddr,
  output logic [7:0]           busWordAddr,
  input  logic                 busAck,
  input  logic                 busNack,
  input  logic [7:0]           busData,
  output logic [7:0]           ownAddr,
  output logic [REC_LEN*8-1:0] cfgFlat,
  output logic                 allDone,
  output logic                 loadErr
);

  phase_t  phase;
  ldStrb_t strb;
  logic    hdrLast;
  logic    chkPos;
  logic    mapOn;
  logic    chkOk;

  eeld_ctrl #(.MAX_RETRY(MAX_RETRY)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .chainEnN (chainEnN),
    .busAck   (busAck),
    .busNack  (busNack),
    .hdrLast  (hdrLast),
    .chkPos   (chkPos),
    .mapOn    (mapOn),
    .chkOk    (chkOk),
    .phase    (phase),
    .reqOn    (busReq),
    .strb     (strb)
  );

  eeld_dpath #(
    .REC_LEN   (REC_LEN),
    .HDR_LEN   (HDR_LEN),
    .STRAP_W   (STRAP_W),
    .EE_AW     (EE_AW),
    .EE_DEV    (EE_DEV),
    .OWN_BASE  (OWN_BASE),
    .FIXED_PAT (FIXED_PAT)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strap    (strap),
    .busData  (busData),
    .phase    (phase),
    .strb     (strb),
    .devAddr  (busDevAddr),
    .wordAddr (busWordAddr),
    .ownAddr  (ownAddr),
    .hdrLast  (hdrLast),
    .chkPos   (chkPos),
    .mapOn    (mapOn),
    .chkOk    (chkOk),
    .errQ     (loadErr),
    .doneQ    (allDone),
    .cfgFlat  (cfgFlat)
  );

endmodule

// File: rtl/eeld_autoload_chk.sv
module eeld_autoload_chk #(
  parameter int REC_LEN = 37
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 chainEnN,
  input logic                 busReq,
  input logic [7:0]           busDevAddr,
  input logic [7:0]           busWordAddr,
  input logic                 busAck,
  input logic                 busNack,
  input logic [REC_LEN*8-1:0] cfgFlat,
  input logic                 allDone,
  input logic                 loadErr
);

  logic started;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          started <= 1'b0;
    else if (!chainEnN) started <= 1'b1;
  end

  p_wait_chain_r2: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> !busReq);

  p_dev_form_r5: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busDevAddr[7:3] == 5'b10100) && !busDevAddr[0]);

  p_err_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadErr |-> allDone);

  p_cfg_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgFlat) |-> allDone && !loadErr);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    allDone |=> allDone);

  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    allDone |-> !busReq);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && !busNack |=> busReq && $stable(busDevAddr) && $stable(busWordAddr));

  p_req_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    busReq && (busAck || busNack) |=> !busReq);

endmodule

bind eeld_autoload eeld_autoload_chk #(.REC_LEN(REC_LEN)) chk_i (.*);

// File: tb/eeld_autoload_tb_top.sv
module eeld_autoload_tb_top;

  localparam int RL = 37;

  typedef struct packed {
    logic [3:0] strap;
    logic [2:0] flags;
    logic [7:0] mapVal;
    logic       corrupt;
    logic [2:0] nacks;
    logic [7:0] seed;
  } vec_t;

  // strap, flags{big,map,crc}, map value, corrupt check byte, refusals, fill seed
  localparam vec_t VECS [9] = '{
    '{4'd0,  3'b000, 8'h00, 1'b0, 3'd0, 8'h11},
    '{4'd2,  3'b001, 8'h00, 1'b0, 3'd0, 8'h22},
    '{4'd7,  3'b101, 8'h00, 1'b0, 3'd0, 8'h33},
    '{4'd3,  3'b011, 8'h40, 1'b0, 3'd0, 8'h44},
    '{4'd1,  3'b001, 8'h00, 1'b1, 3'd0, 8'h55},
    '{4'd15, 3'b100, 8'h00, 1'b0, 3'd2, 8'h66},
    '{4'd4,  3'b000, 8'h00, 1'b0, 3'd4, 8'h77},
    '{4'd0,  3'b000, 8'h00, 1'b1, 3'd0, 8'h88},
    '{4'd6,  3'b111, 8'hC8, 1'b0, 3'd3, 8'h99}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [3:0]      strap = '0;
  logic            chainEnN = 1'b1;
  logic            busAck = 1'b0;
  logic            busNack = 1'b0;
  logic [7:0]      busData = '0;
  logic            busReq;
  logic [7:0]      busDevAddr;
  logic [7:0]      busWordAddr;
  logic [7:0]      ownAddr;
  logic [RL*8-1:0] cfgFlat;
  logic            allDone;
  logic            loadErr;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [1024];
  logic [7:0] traceDev [64];
  logic [7:0] traceWord [64];
  int         traceN = 0;
  int         nackLeft = 0;
  logic [9:0] nackAt = '0;
  logic [9:0] respAddr;

  always #10 clk = ~clk;

  eeld_autoload dut_i (
    .clk(clk), .rstN(rstN), .strap(strap), .chainEnN(chainEnN),
    .busReq(busReq), .busDevAddr(busDevAddr), .busWordAddr(busWordAddr),
    .busAck(busAck), .busNack(busNack), .busData(busData),
    .ownAddr(ownAddr), .cfgFlat(cfgFlat), .allDone(allDone), .loadErr(loadErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] refCrc(input int from);
    logic [7:0] c;
    c = 8'h00;
    for (int k = 0; k < RL; k++) begin
      c = c ^ mem[from + k];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  // EEPROM responder: one byte per request, one cycle of latency
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && busReq) begin
        respAddr = {busDevAddr[2:1], busWordAddr};
        if (traceN < 64) begin
          traceDev[traceN]  = busDevAddr;
          traceWord[traceN] = busWordAddr;
        end
        traceN++;
        @(negedge clk);
        if (nackLeft > 0 && respAddr == nackAt) begin
          nackLeft--;
          busNack = 1'b1;
        end else begin
          busAck  = 1'b1;
          busData = mem[respAddr];
        end
        @(negedge clk);
        busAck  = 1'b0;
        busNack = 1'b0;
      end
    end
  end

  task automatic runVec(input vec_t v, input int id);
    int         start;
    int         n;
    int         mism;
    int         attempts;
    int         settle;
    logic [9:0] e [64];
    logic [7:0] chkByte;
    logic [7:0] expDev;
    logic [7:0] expByte;
    bit         expErr;

    for (int a = 0; a < 1024; a++) mem[a] = 8'(a * 13) ^ v.seed ^ 8'(a >> 5);
    mem[0] = {5'b0, v.flags};
    mem[1] = 8'h3C;
    mem[2] = 8'hC3;
    if (v.flags[1]) begin
      mem[3 + int'(v.strap)] = v.mapVal;
      start = int'(v.mapVal);
    end else begin
      start = 3 + int'(v.strap) * RL;
    end
    chkByte = v.flags[0] ? refCrc(start) : 8'hA5;
    if (v.corrupt) chkByte = chkByte ^ 8'h10;
    mem[start + RL] = chkByte;
    expErr = v.corrupt || (v.nacks >= 3'd4);

    // Expected request sequence (R3, R4, R6, R9)
    n = 0;
    for (int h = 0; h < 3; h++) begin e[n] = 10'(h); n++; end
    if (v.flags[1]) begin e[n] = 10'(3 + int'(v.strap)); n++; end
    attempts = (v.nacks >= 3'd4) ? 4 : int'(v.nacks) + 1;
    for (int r = 0; r < attempts; r++) begin e[n] = 10'(start); n++; end
    if (v.nacks < 3'd4)
      for (int k = 1; k <= RL; k++) begin e[n] = 10'(start + k); n++; end

    @(negedge clk);
    rstN     = 1'b0;
    strap    = v.strap;
    chainEnN = 1'b0;
    nackLeft = int'(v.nacks);
    nackAt   = 10'(start);
    repeat (2) @(negedge clk);
    traceN = 0;
    rstN   = 1'b1;

    settle = 0;
    while (!allDone && settle < 4000) begin @(negedge clk); settle++; end

    // Chain input toggles after completion must not restart (R10)
    chainEnN = 1'b1;
    repeat (3) @(negedge clk);
    chainEnN = 1'b0;
    repeat (4) @(negedge clk);

    check(allDone == 1'b1, "R10", $sformatf("vec %0d done held", id), 32'(allDone), 32'd1);
    check(busReq == 1'b0, "R10", $sformatf("vec %0d no request after done", id), 32'(busReq), 32'd0);
    check(traceN == n, "R3/R4/R9", $sformatf("vec %0d request count", id), 32'(traceN), 32'(n));

    mism = 0;
    for (int i = 0; i < n && i < traceN; i++) begin
      expDev = v.flags[2] ? (8'hA0 | {5'b0, e[i][9:8], 1'b0}) : 8'hA0;
      if (mism == 0 && (traceDev[i] != expDev || traceWord[i] != e[i][7:0]))
        check(1'b0, "R4/R5/R6", $sformatf("vec %0d request %0d address", id, i),
              {16'h0, traceDev[i], traceWord[i]}, {16'h0, expDev, e[i][7:0]});
      if (traceDev[i] != expDev || traceWord[i] != e[i][7:0]) mism++;
    end
    if (mism == 0) check(1'b1, "R5", "addresses", 32'd0, 32'd0);

    check(loadErr == expErr, "R7/R8/R9", $sformatf("vec %0d error flag", id),
          32'(loadErr), 32'(expErr));

    mism = 0;
    for (int k = 0; k < RL; k++) begin
      expByte = expErr ? 8'h00 : mem[start + k];
      if (mism == 0 && cfgFlat[k*8 +: 8] != expByte)
        check(1'b0, "R6/R8", $sformatf("vec %0d register byte %0d", id, k),
              32'(cfgFlat[k*8 +: 8]), 32'(expByte));
      if (cfgFlat[k*8 +: 8] != expByte) mism++;
    end
    if (mism == 0) check(1'b1, "R6", "register file", 32'd0, 32'd0);
  endtask

  initial begin
    // Reset state (R11)
    rstN     = 1'b0;
    chainEnN = 1'b1;
    repeat (3) @(negedge clk);
    check(busReq == 1'b0 && allDone == 1'b0 && loadErr == 1'b0, "R11", "reset outputs",
          {29'd0, busReq, allDone, loadErr}, 32'd0);
    check(cfgFlat == '0, "R11", "reset register file", 32'(cfgFlat[31:0]), 32'd0);

    // Own address from strap (R1)
    for (int s = 0; s < 16; s += 5) begin
      strap = 4'(s);
      #1;
      check(ownAddr == 8'(8'hB0 + 2 * s), "R1", $sformatf("own address strap %0d", s),
            32'(ownAddr), 32'(8'hB0 + 2 * s));
    end

    // Chain enable held high: nothing happens (R2)
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    @(negedge clk);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(traceN == 0 && allDone == 1'b0, "R2", "idle while chain enable high",
          32'(traceN), 32'd0);

    // Table of scenarios
    for (int i = 0; i < 9; i++) runVec(VECS[i], i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule